// File: doc/BRIEF.md
# Busy Timer and Power-Mode Controller

This block tracks how long a serial memory device stays busy after a modifying command, and which power state it is in. A command front-end delivers one strobe per completed command, at the moment chip select returns high on a byte boundary. The strobe carries a 3-bit command code. A protection unit supplies an accept flag that says whether a modifying command may run. Accepted status-register writes, page programs and the three erase sizes each start a countdown with their own length. The write-in-progress flag is held high for that whole countdown. A one-cycle completion pulse then tells the status logic to clear its write-enable latch.

The same state machine handles the low-power behaviour. A power-down command passes through a timed entry phase into deep power-down. In deep power-down only the wake command is honoured, and it passes through a timed release phase back to standby. A single power-good input models supply sensing. While the supply is not good, and for a fixed interval after it becomes good, the block keeps every command gated off. A command-gating mask tells the front-end which command classes it may decode in the current state.

Every duration is a parameter counted in system-clock cycles. The defaults assume a 50 MHz clock and worst-case device timing.

Top module: `busy_pwr_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 5 (lockout), gate_o is 0, and wip_o and done_o are 0. After reset, with pwr_good_i high, state_o stays 5 for exactly T_VSL cycles and then becomes 0 (standby). The state codes are: 0 standby, 1 busy, 2 entering power-down, 3 power-down, 4 releasing, 5 lockout.
- R2: When pwr_good_i is low at a clock edge, the block is in lockout (5) from that edge on. A running operation is abandoned without a done_o pulse, and commands are ignored. Once pwr_good_i is high again, lockout lasts T_VSL more cycles.
- R3: In standby, a strobe (cmd_valid_i=1) with accept_i=1 and a modifying command code starts the busy state from the next cycle. The codes are 1 status write, 2 page program, 3 sector erase, 4 block erase and 5 chip erase. wip_o is then 1 for exactly T_SR, T_PP, T_SE, T_BE or T_CE cycles respectively.
- R4: done_o is 1 for exactly one cycle: the first cycle after the busy state ends, when wip_o is already 0.
- R5: A modifying code with accept_i=0, and code 0 (none), leave the block in standby with wip_o at 0.
- R6: While busy, every strobe is ignored, including the wake code 7. The running countdown is neither restarted nor shortened.
- R7: gate_o bits are: [0] status read, [1] array or ID read, [2] modifying command, [3] power-down entry, [4] wake. gate_o is 5'b11111 in standby, 5'b00001 in busy, 5'b10000 in power-down, and 0 in every other state.
- R8: In standby, code 6 (power-down) moves the block to state 2 for exactly T_DP cycles and then to state 3. accept_i is not needed.
- R9: In power-down, every code other than 7 is ignored. Code 7 moves the block to state 4 for exactly T_RES cycles and then to standby.
- R10: Code 7 in standby leaves the block in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply valid |
| cmd_valid_i | input | 1 | One-cycle strobe: a command completed at chip-select rise |
| cmd_i | input | 3 | Command code (see R3, R8, R9) |
| accept_i | input | 1 | Protection unit allows the modifying command |
| wip_o | output | 1 | Write in progress |
| done_o | output | 1 | Completion pulse that clears the write-enable latch |
| gate_o | output | 5 | Permitted command classes (see R7) |
| state_o | output | 3 | Current state code (see R1) |

## Verification
The bench builds the block with every duration shrunk to a few cycles: status write 3, page program 5, sector erase 7, block erase 9, chip erase 11, power-down entry 4, release 6 and power-up lockout 10. With distinct small values, each operation's busy length can be counted exactly, and a wrong mapping from command code to duration becomes visible. The short page-program window also leaves room to inject competing strobes mid-operation and still confirm the total length. The lockout restart after a supply drop, and the full sleep and wake round trip, fit in a few dozen cycles.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_SR_WR      = 3'd1,
    CMD_PAGE_PROG  = 3'd2,
    CMD_SECT_ERASE = 3'd3,
    CMD_BLK_ERASE  = 3'd4,
    CMD_CHIP_ERASE = 3'd5,
    CMD_PWR_DOWN   = 3'd6,
    CMD_WAKE       = 3'd7
  } bpc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_BUSY     = 3'd1,
    ST_SLEEP_IN = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_WAKE     = 3'd4,
    ST_LOCK     = 3'd5
  } bpc_state_e;

  localparam int unsigned GATE_W    = 5;
  localparam int unsigned G_STAT_RD = 0;
  localparam int unsigned G_ARR_RD  = 1;
  localparam int unsigned G_MODIFY  = 2;
  localparam int unsigned G_PDOWN   = 3;
  localparam int unsigned G_WAKE    = 4;

  function automatic logic is_modify(bpc_cmd_e c);
    return (c == CMD_SR_WR) || (c == CMD_PAGE_PROG) || (c == CMD_SECT_ERASE) ||
           (c == CMD_BLK_ERASE) || (c == CMD_CHIP_ERASE);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bpc_dur_sel.sv
module bpc_dur_sel
  import bpc_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned T_SR  = 1,
  parameter int unsigned T_PP  = 1,
  parameter int unsigned T_SE  = 1,
  parameter int unsigned T_BE  = 1,
  parameter int unsigned T_CE  = 1,
  parameter int unsigned T_DP  = 1,
  parameter int unsigned T_RES = 1
) (
  input  bpc_cmd_e         cmd_i,
  output logic [CNT_W-1:0] load_val_o
);
  // load value is duration-1: the zero cycle is the last one of the phase
  always_comb begin
    unique case (cmd_i)
      CMD_SR_WR:      load_val_o = CNT_W'(T_SR - 1);
      CMD_PAGE_PROG:  load_val_o = CNT_W'(T_PP - 1);
      CMD_SECT_ERASE: load_val_o = CNT_W'(T_SE - 1);
      CMD_BLK_ERASE:  load_val_o = CNT_W'(T_BE - 1);
      CMD_CHIP_ERASE: load_val_o = CNT_W'(T_CE - 1);
      CMD_PWR_DOWN:   load_val_o = CNT_W'(T_DP - 1);
      CMD_WAKE:       load_val_o = CNT_W'(T_RES - 1);
      default:        load_val_o = '0;
    endcase
  end
endmodule

// File: rtl/bpc_timer.sv
module bpc_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bpc_gate.sv
module bpc_gate
  import bpc_pkg::*;
(
  input  bpc_state_e        state_i,
  output logic [GATE_W-1:0] gate_o
);
  always_comb begin
    gate_o = '0;
    unique case (state_i)
      ST_IDLE:  gate_o = '1;
      ST_BUSY:  gate_o[G_STAT_RD] = 1'b1;
      ST_SLEEP: gate_o[G_WAKE] = 1'b1;
      default:  gate_o = '0;
    endcase
  end
endmodule

// File: rtl/busy_pwr_ctrl.sv
module busy_pwr_ctrl
  import bpc_pkg::*;
#(
  parameter int unsigned T_SR  = 750_000,
  parameter int unsigned T_PP  = 32_500,
  parameter int unsigned T_SE  = 15_000_000,
  parameter int unsigned T_BE  = 100_000_000,
  parameter int unsigned T_CE  = 250_000_000,
  parameter int unsigned T_DP  = 500,
  parameter int unsigned T_RES = 440,
  parameter int unsigned T_VSL = 15_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_good_i,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_i,
  input  logic        accept_i,
  output logic        wip_o,
  output logic        done_o,
  output logic [4:0]  gate_o,
  output logic [2:0]  state_o
);
  localparam int unsigned MAX_T = max2(max2(max2(T_SR, T_PP), max2(T_SE, T_BE)),
                                       max2(max2(T_CE, T_DP), max2(T_RES, T_VSL)));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  bpc_cmd_e         cmd;
  bpc_state_e       state_q, state_d;
  logic             tmr_start, tmr_load, tmr_zero, done_d, done_q;
  logic [CNT_W-1:0] dur_val, load_val;

  assign cmd = bpc_cmd_e'(cmd_i);

  bpc_dur_sel #(
    .CNT_W(CNT_W), .T_SR(T_SR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE),
    .T_CE(T_CE), .T_DP(T_DP), .T_RES(T_RES)
  ) u_dur (
    .cmd_i      (cmd),
    .load_val_o (dur_val)
  );

  // supply loss reloads the lockout interval every cycle it persists
  assign tmr_load = tmr_start || !pwr_good_i;
  assign load_val = pwr_good_i ? dur_val : CNT_W'(T_VSL - 1);

  bpc_timer #(.CNT_W(CNT_W), .RST_VAL(T_VSL - 1)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_LOCK:     if (tmr_zero) state_d = ST_IDLE;
      ST_IDLE: begin
        if (cmd_valid_i && is_modify(cmd) && accept_i) begin
          state_d   = ST_BUSY;
          tmr_start = 1'b1;
        end else if (cmd_valid_i && cmd == CMD_PWR_DOWN) begin
          state_d   = ST_SLEEP_IN;
          tmr_start = 1'b1;
        end
      end
      ST_BUSY: if (tmr_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_SLEEP_IN: if (tmr_zero) state_d = ST_SLEEP;
      ST_SLEEP: if (cmd_valid_i && cmd == CMD_WAKE) begin
        state_d   = ST_WAKE;
        tmr_start = 1'b1;
      end
      ST_WAKE:     if (tmr_zero) state_d = ST_IDLE;
      default:     state_d = ST_LOCK;
    endcase
    if (!pwr_good_i) begin
      state_d = ST_LOCK;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  bpc_gate u_gate (
    .state_i (state_q),
    .gate_o  (gate_o)
  );

  assign wip_o   = (state_q == ST_BUSY);
  assign done_o  = done_q;
  assign state_o = state_q;
endmodule

module busy_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_i,
  input logic       accept_i,
  input logic       wip_o,
  input logic       done_o,
  input logic [4:0] gate_o,
  input logic [2:0] state_o
);
  // R3
  wip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_o) |-> $past(cmd_valid_i && accept_i));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wip_o && $past(wip_o)));

  // R2
  brownout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (state_o == 3'd5 && !done_o));

  // R7
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_o |-> (gate_o == 5'b00001));

  // R8
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2));

  // R9
  wake_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |->
      $past(state_o == 3'd3 && cmd_valid_i && cmd_i == 3'd7));

  // R1
  lock_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && $past(state_o) == 3'd5) |-> $past(pwr_good_i));
endmodule

bind busy_pwr_ctrl busy_pwr_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .accept_i    (accept_i),
  .wip_o       (wip_o),
  .done_o      (done_o),
  .gate_o      (gate_o),
  .state_o     (state_o)
);

// File: tb/tb_busy_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_busy_pwr_ctrl;
  localparam int T_SR = 3, T_PP = 5, T_SE = 7, T_BE = 9, T_CE = 11;
  localparam int T_DP = 4, T_RES = 6, T_VSL = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0, pwr_good_i = 1'b1;
  logic       cmd_valid_i = 1'b0, accept_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       wip_o, done_o;
  logic [4:0] gate_o;
  logic [2:0] state_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  busy_pwr_ctrl #(
    .T_SR(T_SR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_CE(T_CE),
    .T_DP(T_DP), .T_RES(T_RES), .T_VSL(T_VSL)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .accept_i(accept_i),
    .wip_o(wip_o), .done_o(done_o), .gate_o(gate_o), .state_o(state_o)
  );

  // {cmd[3:0], accept[3:0], expected busy length[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {4'd1, 4'd1, 8'(T_SR)},
    {4'd2, 4'd1, 8'(T_PP)},
    {4'd3, 4'd1, 8'(T_SE)},
    {4'd4, 4'd1, 8'(T_BE)},
    {4'd5, 4'd1, 8'(T_CE)},
    {4'd2, 4'd0, 8'd0},
    {4'd5, 4'd0, 8'd0},
    {4'd0, 4'd1, 8'd0}
  };

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic a);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = c; accept_i = a;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_i = 3'd0; accept_i = 1'b0;
  endtask

  task automatic measure(logic [2:0] st, output int n);
    n = 0;
    while (state_o == st && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", state_o, 5);
    chk("R1 reset gate", gate_o, 0);
    chk("R1 reset wip", wip_o, 0);
    chk("R1 reset done", done_o, 0);
    rst_ni = 1'b1;
    measure(3'd5, n);
    chk("R1 lockout length", n, T_VSL);
    chk("R1 standby after lockout", state_o, 0);
    chk("R7 standby gate", gate_o, 5'b11111);

    foreach (VEC[i]) begin
      issue(VEC[i][14:12], VEC[i][8]);
      measure(3'd1, n);
      chk($sformatf("R3/R5 vec%0d busy length", i), n, int'(VEC[i][7:0]));
      if (VEC[i][7:0] != 0) begin
        chk("R4 done at end", done_o, 1);
        chk("R4 wip low with done", wip_o, 0);
        @(negedge clk_i);
        chk("R4 done one cycle", done_o, 0);
      end else begin
        chk("R5 stays standby", state_o, 0);
      end
    end

    // R6: strobes during busy are ignored
    issue(3'd2, 1'b1);
    chk("R7 busy gate", gate_o, 5'b00001);
    issue(3'd5, 1'b1);
    issue(3'd7, 1'b0);
    measure(3'd1, n);
    chk("R6 busy not restarted", n + 4, T_PP);
    chk("R6 done after busy", done_o, 1);

    // R8 / R9: power-down round trip
    issue(3'd6, 1'b0);
    chk("R7 entering gate", gate_o, 0);
    measure(3'd2, n);
    chk("R8 entry length", n, T_DP);
    chk("R8 power-down state", state_o, 3);
    chk("R7 power-down gate", gate_o, 5'b10000);
    issue(3'd2, 1'b1);
    chk("R9 program ignored in power-down", state_o, 3);
    issue(3'd1, 1'b1);
    chk("R9 status write ignored in power-down", state_o, 3);
    chk("R9 no wip in power-down", wip_o, 0);
    issue(3'd7, 1'b0);
    measure(3'd4, n);
    chk("R9 release length", n, T_RES);
    chk("R9 standby after release", state_o, 0);

    // R10
    issue(3'd7, 1'b0);
    chk("R10 wake in standby", state_o, 0);
    chk("R10 no wip", wip_o, 0);

    // R2: supply drop mid-operation
    issue(3'd3, 1'b1);
    chk("R2 busy before drop", wip_o, 1);
    pwr_good_i = 1'b0;
    @(negedge clk_i);
    chk("R2 lockout on drop", state_o, 5);
    chk("R2 no done on abandon", done_o, 0);
    issue(3'd2, 1'b1);
    chk("R2 command ignored in lockout", state_o, 5);
    chk("R2 no wip in lockout", wip_o, 0);
    pwr_good_i = 1'b1;
    measure(3'd5, n);
    chk("R2 lockout restart length", n, T_VSL);
    chk("R2 standby after recovery", state_o, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule